// File: doc/BRIEF.md
# Alternate Bit Inversion Codec

This block sits on a serial link and lowers the number of bit transitions in each word. Each serial word goes into a fixed-length delay line. That gives an upstream transition counter time to finish and deliver a one-bit decision for the whole word. When the word reaches the head of the delay line, the block sends it on in one of two forms:
- unchanged, when the decision is low;
- with every even-position bit flipped, when the decision is high.

The first bit of a word is never altered. The decision travels with the word on its own output, aligned with the word's first bit.

The operation is its own inverse. The receiver therefore uses the same module: the receiving instance is given the recovered serial stream and the same decision, and it returns the original word. Input may stream back to back with no idle cycles. The output keeps the same throughput at a fixed latency of `WORD_LEN + 1` cycles.

Top module: `abi_codec`

## Requirements
- R1: While reset is asserted, and after reset until the first valid input bit arrives at the output, the outputs `outBit`, `outValid`, `outStart` and `outDec` are all 0.
- R2: Every input cycle shows up on the output exactly `WORD_LEN + 1` clock cycles later. `outValid` in that cycle equals the `inValid` of that input cycle.
- R3: When the decision for a word is 0, every output bit of that word equals the corresponding input bit.
- R4: When the decision for a word is 1, the bits at even positions (2, 4, 6, ...) are inverted on the output and the bits at odd positions are passed through.
- R5: The bit at position 1 of a word, marked by `inStart`, always leaves unchanged, whatever the decision.
- R6: `outStart` is high only on the first output bit of a word. `outDec` carries the word's decision on every valid output bit of that word and is held constant across the word.
- R7: For a word whose first bit enters in cycle t, the decision is accepted with `decValid` either in cycle t + `WORD_LEN` - 1 or in cycle t + `WORD_LEN`. Either one applies to that word only.
- R8: Bit position is counted over valid bits only and restarts at 1 on every `inStart`. Idle cycles inside a word do not shift the parity, and a new `inStart` before a word completes begins a fresh word.
- R9: Words may follow each other with no idle cycles. A decision for the next word, arriving while the current word is still being emitted, does not change the current word's bits or its `outDec`.
- R10: Passing an encoded word through the block again, with the same decision, yields the original word.
- R11: On cycles where `outValid` is 0, both `outBit` and `outDec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inBit | input | 1 | Serial input bit |
| inValid | input | 1 | Input bit is valid this cycle |
| inStart | input | 1 | Input bit is position 1 of a word |
| decBit | input | 1 | Inversion decision for the pending word |
| decValid | input | 1 | `decBit` is valid this cycle |
| outBit | output | 1 | Serial output bit, encoded or decoded |
| outValid | output | 1 | Output bit is valid this cycle |
| outStart | output | 1 | Output bit is position 1 of a word |
| outDec | output | 1 | Decision applied to the word being emitted |

## Verification
The hardest situation to reach from the ports is the overlap at a word boundary under full load. Two things happen there. The next word's decision arrives while the current word's tail bits are still leaving. Alternatively, the current word's own decision arrives in the same cycle its first bit is taken from the head, so the decision register has to be bypassed. The stimulus builds back-to-back words with alternating decisions and places each decision on an absolute cycle offset from its word's start, using the early slot for some words and the late slot for others. Words with an idle cycle inside, and a word cut short by an early start, check that the position parity follows the valid bits rather than the cycles.

// File: rtl/abi_pkg.sv
package abi_pkg;

  // One stage of the delay line
  typedef struct packed {
    logic data;
    logic valid;
    logic start;
    logic even;
  } abiSlot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic tagEven;  // incoming bit sits at an even position
    logic flip;     // invert the bit now leaving the head
    logic decOut;   // decision for the bit now leaving the head
  } abiStrobe_t;

endpackage

// File: rtl/abi_ctrl.sv
module abi_ctrl
  import abi_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       decBit,
  input  logic       decValid,
  input  logic       headValid,
  input  logic       headStart,
  input  logic       headEven,
  output abiStrobe_t strobe
);

  localparam int POS_W = $clog2(WORD_LEN + 1) + 1;

  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] posNow;
  logic             decPend;
  logic             wordDec;
  logic             activeDec;
  logic             curDec;
  logic             headFirst;

  // Position of the incoming bit: 1 at word start, else one past the last valid bit
  always_comb begin
    posNow = inStart ? POS_W'(1) : posCnt + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posCnt <= '0;
    end else if (inValid) begin
      posCnt <= posNow;
    end
  end

  // Latest delivered decision, with a bypass for the cycle the word leaves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decPend <= 1'b0;
    end else if (decValid) begin
      decPend <= decBit;
    end
  end

  assign activeDec = decValid ? decBit : decPend;
  assign headFirst = headValid & headStart;

  // Decision frozen for the word once its first bit leaves the head
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordDec <= 1'b0;
    end else if (headFirst) begin
      wordDec <= activeDec;
    end
  end

  assign curDec = headFirst ? activeDec : wordDec;

  always_comb begin
    strobe.tagEven = inValid & ~posNow[0];
    strobe.flip    = headValid & headEven & curDec;
    strobe.decOut  = headValid & curDec;
  end

endmodule

// File: rtl/abi_datapath.sv
module abi_datapath
  import abi_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inBit,
  input  logic       inValid,
  input  logic       inStart,
  input  abiStrobe_t strobe,
  output logic       headValid,
  output logic       headStart,
  output logic       headEven,
  output logic       outBit,
  output logic       outValid,
  output logic       outStart,
  output logic       outDec
);

  localparam int DEPTH = WORD_LEN;

  abiSlot_t line [DEPTH];
  abiSlot_t head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line[0] <= '0;
    end else begin
      line[0].data  <= inBit & inValid;
      line[0].valid <= inValid;
      line[0].start <= inStart & inValid;
      line[0].even  <= strobe.tagEven;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line[s] <= '0;
      end else begin
        line[s] <= line[s-1];
      end
    end
  end

  assign head      = line[DEPTH-1];
  assign headValid = head.valid;
  assign headStart = head.start;
  assign headEven  = head.even;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outBit   <= 1'b0;
      outValid <= 1'b0;
      outStart <= 1'b0;
      outDec   <= 1'b0;
    end else begin
      outBit   <= head.data ^ strobe.flip;
      outValid <= head.valid;
      outStart <= head.start;
      outDec   <= strobe.decOut;
    end
  end

endmodule

// File: rtl/abi_codec.sv
module abi_codec
  import abi_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inBit,
  input  logic inValid,
  input  logic inStart,
  input  logic decBit,
  input  logic decValid,
  output logic outBit,
  output logic outValid,
  output logic outStart,
  output logic outDec
);

  abiStrobe_t strobe;
  logic       headValid;
  logic       headStart;
  logic       headEven;

  abi_ctrl #(.WORD_LEN(WORD_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .inStart   (inStart),
    .decBit    (decBit),
    .decValid  (decValid),
    .headValid (headValid),
    .headStart (headStart),
    .headEven  (headEven),
    .strobe    (strobe)
  );

  abi_datapath #(.WORD_LEN(WORD_LEN)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .inBit     (inBit),
    .inValid   (inValid),
    .inStart   (inStart),
    .strobe    (strobe),
    .headValid (headValid),
    .headStart (headStart),
    .headEven  (headEven),
    .outBit    (outBit),
    .outValid  (outValid),
    .outStart  (outStart),
    .outDec    (outDec)
  );

endmodule

// File: rtl/abi_codec_checker.sv
module abi_codec_checker #(
  parameter int WORD_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic inBit,
  input logic inValid,
  input logic inStart,
  input logic outBit,
  input logic outValid,
  input logic outStart,
  input logic outDec
);

  localparam int HIST = WORD_LEN + 1;

  logic [HIST-1:0] histBit;
  logic [HIST-1:0] histValid;
  logic [HIST-1:0] histStart;

  // Record of the inputs over the latency window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      histBit   <= '0;
      histValid <= '0;
      histStart <= '0;
    end else begin
      histBit   <= {histBit[HIST-2:0], inBit & inValid};
      histValid <= {histValid[HIST-2:0], inValid};
      histStart <= {histStart[HIST-2:0], inStart & inValid};
    end
  end

  // R2: valid appears WORD_LEN+1 cycles after the input
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == histValid[HIST-1]);

  // R5: the first bit of a word leaves unchanged
  assert_first_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outStart) |-> (outBit == histBit[HIST-1] && histStart[HIST-1]));

  // R3: a word with a low decision passes through untouched
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outDec) |-> outBit == histBit[HIST-1]);

  // R6: start marks a valid bit
  assert_start_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outStart |-> outValid);

  // R6: decision stays constant inside a word
  assert_dec_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outStart && $past(outValid)) |-> $stable(outDec));

  // R11: idle output is low
  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!outBit && !outDec));

endmodule

bind abi_codec abi_codec_checker #(.WORD_LEN(WORD_LEN)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inBit    (inBit),
  .inValid  (inValid),
  .inStart  (inStart),
  .outBit   (outBit),
  .outValid (outValid),
  .outStart (outStart),
  .outDec   (outDec)
);

// File: tb/abi_codec_bench.sv
module abi_codec_bench;

  localparam int L    = 8;
  localparam int MAXN = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inBit = 1'b0, inValid = 1'b0, inStart = 1'b0;
  logic decBit = 1'b0, decValid = 1'b0;
  logic outBit, outValid, outStart, outDec;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic sBit [MAXN];
  logic sVal [MAXN];
  logic sSta [MAXN];
  logic sDecB [MAXN];
  logic sDecV [MAXN];
  logic [3:0] expOut [MAXN];  // {valid, start, dec, bit}
  int nCyc;
  int stimLen;
  logic [L-1:0] capWord;
  int capCount;

  always #4 clk = ~clk;  // 125 MHz

  abi_codec #(.WORD_LEN(L)) u_abi_codec (
    .clk(clk), .rst_n(rst_n), .inBit(inBit), .inValid(inValid), .inStart(inStart),
    .decBit(decBit), .decValid(decValid), .outBit(outBit), .outValid(outValid),
    .outStart(outStart), .outDec(outDec)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearStim();
    for (int i = 0; i < MAXN; i++) begin
      sBit[i] = 0; sVal[i] = 0; sSta[i] = 0; sDecB[i] = 0; sDecV[i] = 0; expOut[i] = 4'b0;
    end
    nCyc = 0;
    stimLen = 0;
  endtask

  // First bit sent is data[0]; position p = b + 1; even positions flip when dec = 1
  task automatic addWord(input logic [L-1:0] data, input int nBits, input bit dec,
                         input bit late, input int gapAt);
    int startIdx;
    int slot;
    logic e;
    startIdx = nCyc;
    for (int b = 0; b < nBits; b++) begin
      if (b == gapAt) nCyc++;
      e = data[b] ^ (dec & (b % 2 == 1));
      sBit[nCyc] = data[b];
      sVal[nCyc] = 1'b1;
      sSta[nCyc] = (b == 0);
      expOut[nCyc] = {1'b1, (b == 0), dec, e};
      nCyc++;
    end
    slot = startIdx + L - 1 + (late ? 1 : 0);
    sDecV[slot] = 1'b1;
    sDecB[slot] = dec;
    if (slot + 1 > stimLen) stimLen = slot + 1;
    if (nCyc > stimLen) stimLen = nCyc;
  endtask

  task automatic runStim(input string req);
    int total;
    int k;
    total = stimLen + L + 2;
    capCount = 0;
    capWord = '0;
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      if (j >= L + 1) begin
        k = j - L - 1;
        check({outValid, outStart, outDec, outBit} == expOut[k], req,
              {4'b0, outValid, outStart, outDec, outBit}, {4'b0, expOut[k]});
        if (outValid && capCount < L) begin
          capWord[capCount] = outBit;
          capCount++;
        end
      end
      inBit    = (j < MAXN) ? sBit[j]  : 1'b0;
      inValid  = (j < MAXN) ? sVal[j]  : 1'b0;
      inStart  = (j < MAXN) ? sSta[j]  : 1'b0;
      decBit   = (j < MAXN) ? sDecB[j] : 1'b0;
      decValid = (j < MAXN) ? sDecV[j] : 1'b0;
    end
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({outBit, outValid, outStart, outDec} == 4'b0, "R1",
          {4'b0, outBit, outValid, outStart, outDec}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({outBit, outValid, outStart, outDec} == 4'b0, "R1",
          {4'b0, outBit, outValid, outStart, outDec}, 8'h00);
  endtask

  task automatic testClear();
    clearStim();
    addWord(8'h96, L, 1'b0, 1'b0, -1);
    addWord(8'h3C, L, 1'b0, 1'b1, -1);
    runStim("R3 R2");
  endtask

  task automatic testInvert();
    clearStim();
    addWord(8'h55, L, 1'b1, 1'b0, -1);
    addWord(8'hFF, L, 1'b1, 1'b0, -1);
    addWord(8'h00, L, 1'b1, 1'b1, -1);
    runStim("R4 R5");
  endtask

  task automatic testBackToBack();
    clearStim();
    addWord(8'hC3, L, 1'b1, 1'b1, -1);
    addWord(8'hC3, L, 1'b0, 1'b0, -1);
    addWord(8'h5A, L, 1'b1, 1'b0, -1);
    addWord(8'hA6, L, 1'b0, 1'b1, -1);
    runStim("R7 R9 R6");
  endtask

  task automatic testGap();
    clearStim();
    addWord(8'hE1, L, 1'b1, 1'b0, 3);
    addWord(8'h2D, L, 1'b1, 1'b0, 5);
    runStim("R8 R11");
  endtask

  task automatic testRestart();
    clearStim();
    addWord(8'h05, 3, 1'b0, 1'b0, -1);
    addWord(8'hB7, L, 1'b1, 1'b0, -1);
    runStim("R8 restart");
  endtask

  task automatic testDecode();
    clearStim();
    addWord(8'h0F, L, 1'b1, 1'b0, -1);  // encoded form of A5 under decision 1
    runStim("R10");
    check(capWord == 8'hA5, "R10 decoded word", capWord, 8'hA5);
  endtask

  initial begin
    testReset();
    testClear();
    testInvert();
    testBackToBack();
    testGap();
    testRestart();
    testDecode();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule